// File: doc/BRIEF.md
# Multi-Supply Reset Generator

This block turns three per-rail undervoltage flags into one system reset. Each flag comes from an external comparator as a synchronous digital input and is high while its rail sits below its trip level. Channel 0 watches the 3.3 V rail, channel 1 the 5 V rail and channel 2 an adjustable rail. A flag must stay high for a set number of cycles before the block acts on it. Reset is held while any acknowledged fault remains. Once every monitored rail is good, reset stays asserted for a stretch interval of CLK_HZ/5 cycles, which is 200 ms of the block clock.

Two qualifiers let one physical rail feed both the 3.3 V and 5 V inputs. The first says that the 5 V input tracks the 3.3 V input. The second says the shared rail sits above roughly 4.15 V. When the rail tracks but is not above that level, the 5 V fault is ignored. When both qualifiers are set, the 5 V fault is watched and the 3.3 V fault is ignored. A static enable per channel lets one, two or three rails be watched. A forced-reset request from a push-button controller asserts reset and keeps the stretch counter at zero until the request drops.

Top module: `supply_reset_gen`

## Requirements
- R1: An enabled, unmasked channel whose fault has been acknowledged drives `rst_out_n` low at the next clock edge, and `rst_out_n` stays low while any such fault remains.
- R2: After the last fault flag goes low, `rst_out_n` rises exactly STRETCH_CYC+1 edges later, and not before. STRETCH_CYC = CLK_HZ/5.
- R3: A new fault during the stretch re-asserts reset. The full count starts over once all rails are good again.
- R4: `rst_out` is always the inverse of `rst_out_n`.
- R5: With `trk_3v3` = 1 and `above_hi` = 0, channel 1 faults are ignored. With both set to 1, channel 0 faults are ignored. With `trk_3v3` = 0, both channels are watched whatever `above_hi` is.
- R6: With one shared rail rising (`trk_3v3` = 1), `rst_out_n` goes low, then high, then low, then high. It is low while channel 0 is below its trip level. It is high once channel 0 is good and the rail is below the upper level. It is low again one edge after `above_hi` rises while channel 1 is still below its trip level. It is high STRETCH_CYC+1 edges after channel 1 clears.
- R7: `force_req` = 1 drives `rst_out_n` low at the next edge and holds it low however long the request lasts. `rst_out_n` rises exactly STRETCH_CYC edges after the first edge that samples `force_req` = 0.
- R8: A fault flag is acknowledged only after QUAL_CYC consecutive high samples. A pulse of QUAL_CYC-1 cycles has no effect on the outputs. A pulse of QUAL_CYC cycles gives reset QUAL_CYC+1 edges after the flag rises.
- R9: While `rst_n` is low, and for STRETCH_CYC edges after it rises with no fault present, `rst_out_n` is low.
- R10: `chan_en` bit k (0 = 3.3 V, 1 = 5 V, 2 = adjustable) set to 0 makes a fault on `flt_lo` bit k have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low block reset |
| flt_lo | input | 3 | Per-rail below-threshold flags (bit 0 = 3.3 V, 1 = 5 V, 2 = adjustable) |
| chan_en | input | 3 | Static per-channel monitor enable, same bit order |
| trk_3v3 | input | 1 | 5 V input tracks the 3.3 V input |
| above_hi | input | 1 | Shared rail above the upper (~4.15 V) level |
| force_req | input | 1 | Forced-reset request from the push-button controller |
| rst_out_n | output | 1 | Active-low system reset |
| rst_out | output | 1 | Active-high system reset |

## Verification
A fault flag that rises reaches the outputs QUAL_CYC+1 edges later. That is QUAL_CYC edges to acknowledge it and one edge in the stretch register. A fault flag that falls releases reset STRETCH_CYC+1 edges later, while a dropped forced request releases it after STRETCH_CYC edges, and a qualifier change on an already acknowledged fault takes effect after one edge. The bench drives inputs on falling edges and samples on falling edges. Each release is checked one edge before it is due and again at the edge where it is due. It sweeps all eight enable patterns against every channel and all four qualifier combinations against both shared channels. Expected values come from these edge counts.

// File: rtl/srg_pkg.sv
`timescale 1ns/1ps
package srg_pkg;
   localparam int SRG_NCH = 3;
   localparam int CH_V33  = 0;
   localparam int CH_V50  = 1;
   localparam int CH_ADJ  = 2;
   typedef logic [SRG_NCH-1:0] srg_chan_t;
endpackage

// File: rtl/srg_fault_qual.sv
`timescale 1ns/1ps
module srg_fault_qual #(
   parameter int QUAL_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic flag,
   output logic ack
);
   generate
      if (QUAL_CYC < 1) begin : g_bad
         $error("srg_fault_qual: QUAL_CYC must be at least 1");
      end
      if (QUAL_CYC == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ack <= 1'b0;
            else        ack <= flag;
         end
      end else begin : g_count
         localparam int QW = $clog2(QUAL_CYC + 1);
         logic [QW-1:0] run;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run <= '0;
               ack <= 1'b0;
            end else if (!flag) begin
               run <= '0;
               ack <= 1'b0;
            end else if (run == QW'(QUAL_CYC - 1)) begin
               ack <= 1'b1;
            end else begin
               run <= run + QW'(1);
            end
         end
      end
   endgenerate

   // R8: a low sample withdraws the acknowledgment at once
   p_qual_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !flag |=> !ack);
   // R8: acknowledgment only follows a high sample
   p_qual_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ack) |-> $past(flag));
endmodule

// File: rtl/srg_mask.sv
`timescale 1ns/1ps
module srg_mask
   import srg_pkg::*;
#(
   parameter bit OVERRIDE_EN = 1'b1
) (
   input  srg_chan_t ack,
   input  srg_chan_t en,
   input  logic      trk,
   input  logic      hi,
   output srg_chan_t act
);
   srg_chan_t live;
   assign live = ack & en;

   generate
      if (OVERRIDE_EN) begin : g_ovr
         always_comb begin
            act         = live;
            act[CH_V50] = live[CH_V50] & ~(trk & ~hi);
            act[CH_V33] = live[CH_V33] & ~(trk &  hi);
         end
      end else begin : g_plain
         assign act = live;
      end
   endgenerate
endmodule

// File: rtl/srg_stretch.sv
`timescale 1ns/1ps
module srg_stretch #(
   parameter int STRETCH_CYC = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hold,
   output logic rst_q
);
   localparam int CW = $clog2(STRETCH_CYC + 1);

   generate
      if (STRETCH_CYC < 2) begin : g_bad
         $error("srg_stretch: STRETCH_CYC must be at least 2");
      end
   endgenerate

   logic [CW-1:0] good_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         good_cnt <= '0;
         rst_q    <= 1'b1;
      end else if (hold) begin
         good_cnt <= '0;
         rst_q    <= 1'b1;
      end else if (rst_q) begin
         if (good_cnt == CW'(STRETCH_CYC - 1)) rst_q <= 1'b0;
         else                                  good_cnt <= good_cnt + CW'(1);
      end
   end

   // R1: a held fault always leaves reset asserted
   p_hold_asserts_r1: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> rst_q);
   // R2: no release before the full good interval
   p_no_early_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_q && good_cnt < CW'(STRETCH_CYC - 1)) |=> rst_q);
   // R3: any fault restarts the interval from zero
   p_restart_r3: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> good_cnt == '0);
endmodule

// File: rtl/supply_reset_gen.sv
`timescale 1ns/1ps
module supply_reset_gen
   import srg_pkg::*;
#(
   parameter int CLK_HZ      = 100_000_000,
   parameter int QUAL_CYC    = 1300,
   parameter bit OVERRIDE_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] flt_lo,
   input  logic [2:0] chan_en,
   input  logic       trk_3v3,
   input  logic       above_hi,
   input  logic       force_req,
   output logic       rst_out_n,
   output logic       rst_out
);
   localparam int STRETCH_CYC = CLK_HZ / 5;

   generate
      if (CLK_HZ < 10) begin : g_bad
         $error("supply_reset_gen: CLK_HZ too small for a stretch interval");
      end
   endgenerate

   srg_chan_t ack, act;
   logic      hold, rst_q;

   for (genvar k = 0; k < SRG_NCH; k++) begin : g_ch
      srg_fault_qual #(.QUAL_CYC(QUAL_CYC)) u_qual (
         .clk  (clk),
         .rst_n(rst_n),
         .flag (flt_lo[k]),
         .ack  (ack[k])
      );
   end

   srg_mask #(.OVERRIDE_EN(OVERRIDE_EN)) u_mask (
      .ack(ack),
      .en (chan_en),
      .trk(trk_3v3),
      .hi (above_hi),
      .act(act)
   );

   assign hold = (|act) | force_req;

   srg_stretch #(.STRETCH_CYC(STRETCH_CYC)) u_stretch (
      .clk  (clk),
      .rst_n(rst_n),
      .hold (hold),
      .rst_q(rst_q)
   );

   assign rst_out_n = ~rst_q;
   assign rst_out   = rst_q;

   // R7: a forced request shows on the pin one edge later
   p_force_r7: assert property (@(posedge clk) disable iff (!rst_n)
      force_req |=> !rst_out_n);
   // R5: tracking below the upper level leaves the 5 V fault unheard
   p_ignore5_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (OVERRIDE_EN && trk_3v3 && !above_hi && !force_req &&
       !(ack[CH_V33] && chan_en[CH_V33]) && !(ack[CH_ADJ] && chan_en[CH_ADJ])) |-> !hold);
   // R10: with every channel disabled only the request can hold reset
   p_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (chan_en == '0 && !force_req) |-> !hold);
endmodule

// File: tb/supply_reset_gen_tb.sv
`timescale 1ns/1ps
module supply_reset_gen_tb;
   localparam int CLK_HZ = 100;
   localparam int Q      = 3;
   localparam int S      = CLK_HZ / 5;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [2:0] flt_lo;
   logic [2:0] chan_en;
   logic       trk_3v3, above_hi, force_req;
   logic       rst_out_n, rst_out;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   supply_reset_gen #(.CLK_HZ(CLK_HZ), .QUAL_CYC(Q), .OVERRIDE_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .flt_lo(flt_lo), .chan_en(chan_en),
      .trk_3v3(trk_3v3), .above_hi(above_hi), .force_req(force_req),
      .rst_out_n(rst_out_n), .rst_out(rst_out)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // asserted = 1 means reset is expected active; R4 is checked every time
   task automatic check(input string req, input logic asserted);
      n_chk++;
      if (rst_out_n !== ~asserted || rst_out !== asserted) begin
         n_fail++;
         $display("FAIL %s: rst_out_n=%b rst_out=%b expected rst_out_n=%b rst_out=%b (R4 pair)",
                  req, rst_out_n, rst_out, ~asserted, asserted);
      end
   endtask

   initial begin
      #1_000_000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
      $finish;
   end

   initial begin
      rst_n = 1'b0; flt_lo = '0; chan_en = 3'b111;
      trk_3v3 = 1'b0; above_hi = 1'b0; force_req = 1'b0;
      tick(3);
      check("R9 in reset", 1'b1);
      rst_n = 1'b1;
      tick(S - 1);
      check("R9 before first interval", 1'b1);
      tick(1);
      check("R2 first release", 1'b0);

      // R8 glitch shorter than qualification
      flt_lo[0] = 1'b1; tick(Q - 1); flt_lo[0] = 1'b0;
      tick(5);
      check("R8 short pulse ignored", 1'b0);

      // R8 / R1 qualified fault timing
      flt_lo[0] = 1'b1; tick(Q);
      check("R8 not yet acknowledged", 1'b0);
      tick(1);
      check("R1 reset after acknowledgment", 1'b1);
      tick(7);
      check("R1 held while fault stays", 1'b1);
      flt_lo[0] = 1'b0; tick(S);
      check("R2 one edge early", 1'b1);
      tick(1);
      check("R2 release", 1'b0);

      // R3 restart during stretch
      flt_lo[2] = 1'b1; tick(Q + 1);
      check("R3 first fault", 1'b1);
      flt_lo[2] = 1'b0; tick(S / 2);
      flt_lo[1] = 1'b1; tick(Q + 1);
      check("R3 refault in stretch", 1'b1);
      flt_lo[1] = 1'b0; tick(S);
      check("R3 full count restarted", 1'b1);
      tick(1);
      check("R3 release after restart", 1'b0);

      // R7 forced request
      force_req = 1'b1; tick(1);
      check("R7 force asserts", 1'b1);
      flt_lo[0] = 1'b1; tick(Q + 2); flt_lo[0] = 1'b0;
      tick(3 * S);
      check("R7 force holds", 1'b1);
      force_req = 1'b0; tick(S - 1);
      check("R7 one edge early", 1'b1);
      tick(1);
      check("R7 release", 1'b0);

      // R10 enable sweep
      for (int e = 0; e < 8; e++) begin
         for (int ch = 0; ch < 3; ch++) begin
            chan_en = 3'(e);
            flt_lo[ch] = 1'b1; tick(Q + 1);
            check($sformatf("R10 en=%0d ch=%0d", e, ch), e[ch]);
            flt_lo[ch] = 1'b0; tick(S + 1);
            check($sformatf("R10 recover en=%0d ch=%0d", e, ch), 1'b0);
         end
      end
      chan_en = 3'b111;

      // R5 override sweep
      for (int t = 0; t < 2; t++) begin
         for (int h = 0; h < 2; h++) begin
            for (int ch = 0; ch < 2; ch++) begin
               logic ign;
               trk_3v3 = t[0]; above_hi = h[0];
               ign = (ch == 1 && t == 1 && h == 0) || (ch == 0 && t == 1 && h == 1);
               flt_lo[ch] = 1'b1; tick(Q + 1);
               check($sformatf("R5 trk=%0d hi=%0d ch=%0d", t, h, ch), ~ign);
               flt_lo[ch] = 1'b0; tick(S + 1);
               check($sformatf("R5 recover trk=%0d hi=%0d ch=%0d", t, h, ch), 1'b0);
            end
         end
      end

      // R6 shared rail ramp
      trk_3v3 = 1'b1; above_hi = 1'b0;
      flt_lo = 3'b011; tick(Q + 1);
      check("R6 low below 3.3 V trip", 1'b1);
      flt_lo = 3'b010; tick(S);
      check("R6 one edge early", 1'b1);
      tick(1);
      check("R6 high in 3.3 V range", 1'b0);
      above_hi = 1'b1; tick(1);
      check("R6 low above upper level", 1'b1);
      flt_lo = 3'b000; tick(S);
      check("R6 one edge early at 5 V", 1'b1);
      tick(1);
      check("R6 high above 5 V trip", 1'b0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule